// File: doc/BRIEF.md
# Prioritised Interrupt Requester and Acknowledge Responder

This block collects eight interrupt sources and presents them on seven active-low interrupt request lines. It answers interrupt-acknowledge cycles that arrive through a daisy chain. Four of the sources are queue-overflow events. Each of these takes its request level and 8-bit vector from a small programmable register, and it is posted the moment the event pulses. The other four sources are queue entries. Each entry carries its own level and vector with the request. A source holds one pending slot, and the level in that slot (1 to 7) chooses which request line the source pulls low.

When an acknowledge cycle begins, the block compares the acknowledged level with the levels of its pending sources. If the block owns the cycle, it selects the highest-priority pending source at that level, returns that source's vector with a data strobe, and drops that source's request in the same clock. If no source matches, the block passes the acknowledge on to the next device in the chain. The block gives one answer per acknowledge cycle and releases its outputs once the incoming acknowledge goes high.

Top module: `irq_daisy_responder`

## Requirements
- R1: After reset all seven request lines are high, `iackout_n` and `dtack_n` are high, `vec_oe` is low, `vec_out` is 0, and no source is pending (`q_pending` = 0).
- R2: A pulse on `full_evt[i]` posts overflow source i at the next clock edge. The level and vector are taken from that source's register as it stood before that edge.
- R3: If the register level of an overflow source is 0, its event pulse is ignored and no request line changes.
- R4: A queue request (`q_valid[i]`) with a nonzero level is latched only when slot i is empty, and `q_pending[i]` then reads 1. A request made while the slot is pending, or a request with level 0, is ignored.
- R5: `irq_n[k]` is low exactly when some pending source holds level k+1.
- R6: At the first clock edge at which `iackin_n` is sampled low, a matching source causes the following: `dtack_n` goes low, `vec_oe` goes high, `vec_out` takes that source's vector, and `iackout_n` stays high.
- R7: Among pending sources at the acknowledged level, priority runs from overflow 0 to overflow 3, then from queue 0 to queue 3. Sources are indexed 0 to 7 in that order.
- R8: The acknowledged source stops pending at the same edge at which `dtack_n` goes low (release on acknowledge). Its request line rises if no other source holds that level.
- R9: If no pending source matches, `iackout_n` goes low at that edge, `dtack_n` stays high and nothing is cleared.
- R10: While `iackin_n` stays low after the answer, the outputs hold and no further source is cleared. At the first edge with `iackin_n` high, `dtack_n` and `iackout_n` go high, `vec_oe` goes low and `vec_out` returns to 0.
- R11: An acknowledged level of 0 never matches and is always passed on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for an overflow-source register |
| cfg_sel | input | 2 | Selects the overflow source being written |
| cfg_level | input | 3 | Level to store (0 disables the source) |
| cfg_vector | input | 8 | Vector to store |
| full_evt | input | 4 | One pulse per overflow event, one bit per source |
| q_valid | input | 4 | Queue entry request, one bit per queue |
| q_level | input | 12 | Queue entry levels, 3 bits per queue, queue 0 in the low bits |
| q_vector | input | 32 | Queue entry vectors, 8 bits per queue, queue 0 in the low bits |
| q_pending | output | 4 | Queue slot i is occupied |
| irq_n | output | 7 | Active-low request lines; bit k is level k+1 |
| iackin_n | input | 1 | Incoming daisy-chain acknowledge, active low |
| ack_level | input | 3 | Level being acknowledged (address bits 3:1) |
| iackout_n | output | 1 | Outgoing daisy-chain acknowledge, active low |
| dtack_n | output | 1 | Answer strobe, active low |
| vec_oe | output | 1 | Vector is being driven |
| vec_out | output | 8 | Vector of the answered source |

## Verification
The checker properties hold on every cycle. They cover the following: the answer strobe and the pass-on output are never low together; either one falls only after the acknowledge input was low; both release once the acknowledge input is high; a level-0 acknowledge is always passed on; an answer removes exactly one pending source; and the request lines are idle exactly when nothing is pending. Some behaviour only the bench scenarios can show, because it needs a reference model of the sources. This covers which source wins at a shared level, which vector comes back, that a disabled overflow register or an occupied queue slot swallows a request, and that the register contents are captured at posting time.

// File: rtl/irq_daisy_pkg.sv
package irq_daisy_pkg;
   localparam int DEF_LEVEL_W  = 3;
   localparam int DEF_VECTOR_W = 8;

   // decode a one-hot line index for a level value, level 0 maps to no line
   function automatic int level_to_line(input int lvl);
      return lvl - 1;
   endfunction
endpackage

// File: rtl/irq_cfg_bank.sv
module irq_cfg_bank #(
   parameter int N_ENT    = 4,
   parameter int LEVEL_W  = 3,
   parameter int VECTOR_W = 8,
   parameter int SEL_W    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [SEL_W-1:0]          sel,
   input  logic [LEVEL_W-1:0]        wr_level,
   input  logic [VECTOR_W-1:0]       wr_vector,
   output logic [N_ENT*LEVEL_W-1:0]  lvl_flat,
   output logic [N_ENT*VECTOR_W-1:0] vec_flat
);
   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lvl_flat[i*LEVEL_W +: LEVEL_W]   <= '0;
            vec_flat[i*VECTOR_W +: VECTOR_W] <= '0;
         end else if (we && sel == SEL_W'(i)) begin
            lvl_flat[i*LEVEL_W +: LEVEL_W]   <= wr_level;
            vec_flat[i*VECTOR_W +: VECTOR_W] <= wr_vector;
         end
      end
   end
endmodule

// File: rtl/irq_src_slot.sv
module irq_src_slot #(
   parameter int LEVEL_W  = 3,
   parameter int VECTOR_W = 8,
   parameter bit REPOST   = 1'b1  // 1: a new post overwrites a pending slot
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                post,
   input  logic [LEVEL_W-1:0]  post_level,
   input  logic [VECTOR_W-1:0] post_vector,
   input  logic                clr,
   output logic                pend,
   output logic [LEVEL_W-1:0]  pend_level,
   output logic [VECTOR_W-1:0] pend_vector
);
   logic take;

   if (REPOST) begin : g_repost
      assign take = post && (post_level != '0);
   end else begin : g_hold
      assign take = post && (post_level != '0) && !pend;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend        <= 1'b0;
         pend_level  <= '0;
         pend_vector <= '0;
      end else if (take) begin
         pend        <= 1'b1;
         pend_level  <= post_level;
         pend_vector <= post_vector;
      end else if (clr) begin
         pend        <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N_SRC   = 8,
   parameter int LEVEL_W = 3,
   parameter int IDX_W   = 3
) (
   input  logic [N_SRC-1:0]         pend,
   input  logic [N_SRC*LEVEL_W-1:0] lvl_flat,
   input  logic [LEVEL_W-1:0]       ack_level,
   output logic                     hit,
   output logic [IDX_W-1:0]         idx
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      // scan from the lowest priority upward so the lowest index is kept last
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (pend[i] && ack_level != '0 &&
             lvl_flat[i*LEVEL_W +: LEVEL_W] == ack_level) begin
            hit = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_line_drive.sv
module irq_line_drive #(
   parameter int N_SRC   = 8,
   parameter int LEVEL_W = 3,
   parameter int N_LINES = 7
) (
   input  logic [N_SRC-1:0]         pend,
   input  logic [N_SRC*LEVEL_W-1:0] lvl_flat,
   output logic [N_LINES-1:0]       irq_n
);
   for (genvar l = 0; l < N_LINES; l++) begin : g_line
      logic any;
      always_comb begin
         any = 1'b0;
         for (int i = 0; i < N_SRC; i++)
            any = any | (pend[i] && lvl_flat[i*LEVEL_W +: LEVEL_W] == LEVEL_W'(l + 1));
      end
      assign irq_n[l] = ~any;
   end
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
   parameter int VECTOR_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                iackin_n,
   input  logic                hit,
   input  logic [VECTOR_W-1:0] hit_vector,
   output logic                clr_en,
   output logic                iackout_n,
   output logic                dtack_n,
   output logic                vec_oe,
   output logic [VECTOR_W-1:0] vec_out
);
   logic busy;

   assign clr_en = !iackin_n && !busy && hit;

   always_ff @(posedge clk) begin
      if (!rst_n || iackin_n) begin
         busy      <= 1'b0;
         dtack_n   <= 1'b1;
         iackout_n <= 1'b1;
         vec_oe    <= 1'b0;
         vec_out   <= '0;
      end else if (!busy) begin
         busy <= 1'b1;
         if (hit) begin
            dtack_n <= 1'b0;
            vec_oe  <= 1'b1;
            vec_out <= hit_vector;
         end else begin
            iackout_n <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/irq_daisy_responder.sv
module irq_daisy_responder #(
   parameter int N_FULL   = 4,
   parameter int N_QUEUE  = 4,
   parameter int LEVEL_W  = irq_daisy_pkg::DEF_LEVEL_W,
   parameter int VECTOR_W = irq_daisy_pkg::DEF_VECTOR_W,
   localparam int SEL_W   = (N_FULL > 1) ? $clog2(N_FULL) : 1,
   localparam int N_LINES = (1 << LEVEL_W) - 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [SEL_W-1:0]            cfg_sel,
   input  logic [LEVEL_W-1:0]          cfg_level,
   input  logic [VECTOR_W-1:0]         cfg_vector,
   input  logic [N_FULL-1:0]           full_evt,
   input  logic [N_QUEUE-1:0]          q_valid,
   input  logic [N_QUEUE*LEVEL_W-1:0]  q_level,
   input  logic [N_QUEUE*VECTOR_W-1:0] q_vector,
   output logic [N_QUEUE-1:0]          q_pending,
   output logic [N_LINES-1:0]          irq_n,
   input  logic                        iackin_n,
   input  logic [LEVEL_W-1:0]          ack_level,
   output logic                        iackout_n,
   output logic                        dtack_n,
   output logic                        vec_oe,
   output logic [VECTOR_W-1:0]         vec_out
);
   localparam int N_SRC = N_FULL + N_QUEUE;
   localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (LEVEL_W < 1 || LEVEL_W > 4) begin : g_bad_level
      $error("LEVEL_W out of range");
   end
   if (VECTOR_W < 1) begin : g_bad_vector
      $error("VECTOR_W must be positive");
   end
   if (N_FULL < 1 || N_QUEUE < 1) begin : g_bad_count
      $error("need at least one source of each kind");
   end

   logic [N_FULL*LEVEL_W-1:0]  cfg_lvl_flat;
   logic [N_FULL*VECTOR_W-1:0] cfg_vec_flat;
   logic [N_SRC-1:0]           src_pend;
   logic [N_SRC-1:0]           src_clr;
   logic [N_SRC*LEVEL_W-1:0]   src_lvl;
   logic [N_SRC*VECTOR_W-1:0]  src_vec;
   logic                       pick_hit;
   logic [IDX_W-1:0]           pick_idx;
   logic [VECTOR_W-1:0]        hit_vector;
   logic                       clr_en;

   irq_cfg_bank #(
      .N_ENT(N_FULL), .LEVEL_W(LEVEL_W), .VECTOR_W(VECTOR_W), .SEL_W(SEL_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .wr_level(cfg_level), .wr_vector(cfg_vector),
      .lvl_flat(cfg_lvl_flat), .vec_flat(cfg_vec_flat)
   );

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign src_clr[i] = clr_en && (pick_idx == IDX_W'(i));
      if (i < N_FULL) begin : g_full
         irq_src_slot #(.LEVEL_W(LEVEL_W), .VECTOR_W(VECTOR_W), .REPOST(1'b1)) u_slot (
            .clk(clk), .rst_n(rst_n), .post(full_evt[i]),
            .post_level(cfg_lvl_flat[i*LEVEL_W +: LEVEL_W]),
            .post_vector(cfg_vec_flat[i*VECTOR_W +: VECTOR_W]),
            .clr(src_clr[i]), .pend(src_pend[i]),
            .pend_level(src_lvl[i*LEVEL_W +: LEVEL_W]),
            .pend_vector(src_vec[i*VECTOR_W +: VECTOR_W])
         );
      end else begin : g_queue
         localparam int Q = i - N_FULL;
         irq_src_slot #(.LEVEL_W(LEVEL_W), .VECTOR_W(VECTOR_W), .REPOST(1'b0)) u_slot (
            .clk(clk), .rst_n(rst_n), .post(q_valid[Q]),
            .post_level(q_level[Q*LEVEL_W +: LEVEL_W]),
            .post_vector(q_vector[Q*VECTOR_W +: VECTOR_W]),
            .clr(src_clr[i]), .pend(src_pend[i]),
            .pend_level(src_lvl[i*LEVEL_W +: LEVEL_W]),
            .pend_vector(src_vec[i*VECTOR_W +: VECTOR_W])
         );
         assign q_pending[Q] = src_pend[i];
      end
   end

   irq_prio_pick #(.N_SRC(N_SRC), .LEVEL_W(LEVEL_W), .IDX_W(IDX_W)) u_pick (
      .pend(src_pend), .lvl_flat(src_lvl), .ack_level(ack_level),
      .hit(pick_hit), .idx(pick_idx)
   );

   assign hit_vector = src_vec[pick_idx*VECTOR_W +: VECTOR_W];

   irq_line_drive #(.N_SRC(N_SRC), .LEVEL_W(LEVEL_W), .N_LINES(N_LINES)) u_lines (
      .pend(src_pend), .lvl_flat(src_lvl), .irq_n(irq_n)
   );

   irq_ack_ctrl #(.VECTOR_W(VECTOR_W)) u_ack (
      .clk(clk), .rst_n(rst_n), .iackin_n(iackin_n), .hit(pick_hit),
      .hit_vector(hit_vector), .clr_en(clr_en), .iackout_n(iackout_n),
      .dtack_n(dtack_n), .vec_oe(vec_oe), .vec_out(vec_out)
   );
endmodule

// File: rtl/irq_daisy_checker.sv
module irq_daisy_checker #(
   parameter int N_SRC   = 8,
   parameter int N_FULL  = 4,
   parameter int N_QUEUE = 4,
   parameter int LEVEL_W = 3,
   parameter int N_LINES = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               iackin_n,
   input logic [LEVEL_W-1:0] ack_level,
   input logic               iackout_n,
   input logic               dtack_n,
   input logic               vec_oe,
   input logic [N_FULL-1:0]  full_evt,
   input logic [N_QUEUE-1:0] q_valid,
   input logic [N_LINES-1:0] irq_n,
   input logic [N_SRC-1:0]   src_pend
);
   assert_never_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(!dtack_n && !iackout_n));

   assert_answer_after_iack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dtack_n) |-> $past(!iackin_n));

   assert_pass_after_iack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iackout_n) |-> $past(!iackin_n));

   assert_release_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      iackin_n |=> (dtack_n && iackout_n && !vec_oe));

   assert_oe_with_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_oe |-> !dtack_n);

   assert_level0_passes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(iackin_n) && ack_level == '0) |=> !iackout_n);

   assert_one_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(dtack_n) && $past(full_evt == '0 && q_valid == '0))
         |-> ($countones(src_pend) + 1 == $countones($past(src_pend))));

   assert_lines_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pend == '0) |-> (&irq_n));

   assert_lines_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pend != '0) |-> !(&irq_n));
endmodule

bind irq_daisy_responder irq_daisy_checker #(
   .N_SRC(N_FULL + N_QUEUE), .N_FULL(N_FULL), .N_QUEUE(N_QUEUE),
   .LEVEL_W(LEVEL_W), .N_LINES((1 << LEVEL_W) - 1)
) u_irq_daisy_checker (
   .clk(clk), .rst_n(rst_n), .iackin_n(iackin_n), .ack_level(ack_level),
   .iackout_n(iackout_n), .dtack_n(dtack_n), .vec_oe(vec_oe),
   .full_evt(full_evt), .q_valid(q_valid), .irq_n(irq_n), .src_pend(src_pend)
);

// File: tb/irq_daisy_responder_bench.sv
module irq_daisy_responder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [2:0]  cfg_level = '0;
   logic [7:0]  cfg_vector = '0;
   logic [3:0]  full_evt = '0;
   logic [3:0]  q_valid = '0;
   logic [11:0] q_level = '0;
   logic [31:0] q_vector = '0;
   logic [3:0]  q_pending;
   logic [6:0]  irq_n;
   logic        iackin_n = 1'b1;
   logic [2:0]  ack_level = '0;
   logic        iackout_n, dtack_n, vec_oe;
   logic [7:0]  vec_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference model
   bit m_pend[8];
   int m_lvl[8];
   int m_vec[8];
   int c_lvl[4];
   int c_vec[4];
   bit m_busy, m_dtack_n, m_iout_n, m_oe;
   int m_vecout;

   always #2 clk = ~clk;

   irq_daisy_responder u_irq_daisy_responder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_level(cfg_level), .cfg_vector(cfg_vector), .full_evt(full_evt),
      .q_valid(q_valid), .q_level(q_level), .q_vector(q_vector),
      .q_pending(q_pending), .irq_n(irq_n), .iackin_n(iackin_n),
      .ack_level(ack_level), .iackout_n(iackout_n), .dtack_n(dtack_n),
      .vec_oe(vec_oe), .vec_out(vec_out)
   );

   function automatic int pick(input int lvl);
      for (int i = 0; i < 8; i++)
         if (m_pend[i] && lvl != 0 && m_lvl[i] == lvl) return i;
      return -1;
   endfunction

   function automatic logic [6:0] exp_irq();
      logic [6:0] r = 7'h7f;
      for (int i = 0; i < 8; i++)
         if (m_pend[i]) r[m_lvl[i] - 1] = 1'b0;
      return r;
   endfunction

   function automatic logic [3:0] exp_qp();
      logic [3:0] r;
      for (int i = 0; i < 4; i++) r[i] = m_pend[4 + i];
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 8; i++) begin m_pend[i] = 0; m_lvl[i] = 0; m_vec[i] = 0; end
      for (int i = 0; i < 4; i++) begin c_lvl[i] = 0; c_vec[i] = 0; end
      m_busy = 0; m_dtack_n = 1; m_iout_n = 1; m_oe = 0; m_vecout = 0;
   endtask

   // model of one clock edge with the inputs currently driven
   task automatic model_edge();
      bit old[8];
      int w;
      for (int i = 0; i < 8; i++) old[i] = m_pend[i];
      if (iackin_n) begin
         m_busy = 0; m_dtack_n = 1; m_iout_n = 1; m_oe = 0; m_vecout = 0;
      end else if (!m_busy) begin
         m_busy = 1;
         w = pick(int'(ack_level));
         if (w >= 0) begin
            m_dtack_n = 0; m_oe = 1; m_vecout = m_vec[w]; m_pend[w] = 0;
         end else m_iout_n = 0;
      end
      for (int i = 0; i < 4; i++) begin
         if (full_evt[i] && c_lvl[i] != 0) begin
            m_pend[i] = 1; m_lvl[i] = c_lvl[i]; m_vec[i] = c_vec[i];
         end
         if (q_valid[i] && !old[4 + i] && q_level[i*3 +: 3] != 0) begin
            m_pend[4 + i] = 1; m_lvl[4 + i] = int'(q_level[i*3 +: 3]);
            m_vec[4 + i] = int'(q_vector[i*8 +: 8]);
         end
      end
      if (cfg_we) begin
         c_lvl[cfg_sel] = int'(cfg_level); c_vec[cfg_sel] = int'(cfg_vector);
      end
   endtask

   task automatic compare_all();
      check("R5 irq_n", 32'(irq_n), 32'(exp_irq()));
      check("R9 iackout_n", 32'(iackout_n), 32'(m_iout_n));
      check("R6 dtack_n", 32'(dtack_n), 32'(m_dtack_n));
      check("R6 vec_oe", 32'(vec_oe), 32'(m_oe));
      check("R7 vec_out", 32'(vec_out), 32'(m_vecout));
      check("R4 q_pending", 32'(q_pending), 32'(exp_qp()));
   endtask

   task automatic tick();
      model_edge();
      @(negedge clk);
      compare_all();
      cfg_we = 0; full_evt = '0; q_valid = '0;
   endtask

   task automatic idle_ack();
      iackin_n = 1'b1;
      tick();
   endtask

   initial begin
      int seed;
      int ack_left;
      int gap;
      seed = $urandom(32'd1995);
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq_n", 32'(irq_n), 32'h7f);
      check("R1 iackout_n", 32'(iackout_n), 32'h1);
      check("R1 dtack_n", 32'(dtack_n), 32'h1);
      check("R1 vec_oe", 32'(vec_oe), 32'h0);
      check("R1 vec_out", 32'(vec_out), 32'h0);
      check("R1 q_pending", 32'(q_pending), 32'h0);

      // R2 overflow 0 at level 3 vector A5
      cfg_we = 1; cfg_sel = 0; cfg_level = 3; cfg_vector = 8'hA5; tick();
      full_evt = 4'b0001; tick();
      check("R2 level3 line", 32'(irq_n), 32'h7b);

      // R3 overflow 1 with level 0 is ignored
      cfg_we = 1; cfg_sel = 1; cfg_level = 0; cfg_vector = 8'h77; tick();
      full_evt = 4'b0010; tick();
      check("R3 no new line", 32'(irq_n), 32'h7b);

      // R4 queue 0 at level 3, then a second request while occupied
      q_valid = 4'b0001; q_level = 12'h003; q_vector = 32'h11; tick();
      check("R4 slot taken", 32'(q_pending), 32'h1);
      q_valid = 4'b0001; q_level = 12'h005; q_vector = 32'h22; tick();
      check("R4 busy slot ignores", 32'(irq_n), 32'h7b);
      q_valid = 4'b0010; q_level = 12'h000; tick();
      check("R4 level0 entry ignored", 32'(q_pending), 32'h1);

      // R6 R7 acknowledge level 3: overflow 0 beats queue 0
      iackin_n = 0; ack_level = 3; tick();
      check("R7 winner vector", 32'(vec_out), 32'hA5);
      check("R6 strobe low", 32'(dtack_n), 32'h0);
      check("R8 line still held by queue0", 32'(irq_n), 32'h7b);
      tick();
      check("R10 held, queue0 kept", 32'(q_pending), 32'h1);
      idle_ack();
      check("R10 release strobe", 32'(dtack_n), 32'h1);
      iackin_n = 0; ack_level = 3; tick();
      check("R8 queue0 answered", 32'(vec_out), 32'h11);
      check("R8 line released", 32'(irq_n), 32'h7f);
      idle_ack();

      // R9 no match, R11 level 0
      iackin_n = 0; ack_level = 5; tick();
      check("R9 passed on", 32'(iackout_n), 32'h0);
      idle_ack();
      iackin_n = 0; ack_level = 0; tick();
      check("R11 level0 passed", 32'(iackout_n), 32'h0);
      idle_ack();

      // constrained random traffic
      ack_left = 0; gap = 2;
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(7) == 0) begin
            cfg_we = 1; cfg_sel = 2'($urandom_range(3));
            cfg_level = 3'($urandom_range(7)); cfg_vector = 8'($urandom);
         end
         for (int i = 0; i < 4; i++) begin
            full_evt[i] = ($urandom_range(15) == 0);
            q_valid[i]  = ($urandom_range(3) == 0);
            q_level[i*3 +: 3]  = 3'($urandom_range(7));
            q_vector[i*8 +: 8] = 8'($urandom);
         end
         if (ack_left > 0) begin
            ack_left--;
            if (ack_left == 0) iackin_n = 1;
         end else if (gap > 0) begin
            gap--;
         end else if ($urandom_range(3) == 0) begin
            iackin_n = 0; ack_level = 3'($urandom_range(7));
            ack_left = $urandom_range(4, 1); gap = 1;
         end
         tick();
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule